// File: doc/BRIEF.md
# Banked GPIO Edge/Level Interrupt Controller

The controller watches GPIO input lines grouped into banks of up to 32 lines and merges them into a single interrupt request. Every line has three pieces of state: a 4-bit trigger code, an enable bit and a sticky pending bit. Software programs the block through a plain 32-bit register port. Each bank has its own window of registers. A line's pending bit is cleared by writing a one to it.

Each input passes through a two-stage synchroniser before detection. Edge modes compare the synchronised value with its value one clock earlier. Level modes set the pending bit on every clock while the level holds. A per-line qualifier input, driven by the pin multiplexer outside the block, states whether the pin is in its interrupt function. Lines without that qualifier never become pending. Each bank also holds a debounce-select word, which the block only stores.

Top module: `gpio_eint_ctrl`

## Requirements
- R1: Bank b decodes the aligned word addresses from 0x200+0x20*b upward. Line n's trigger code is the 4-bit field at bits 4*(n mod 8) of the word at window offset 4*(n/8), and it reads back as written.
- R2: Trigger codes: 0 fires on a rising edge and 1 on a falling edge. 2 fires while the line is high and 3 while it is low. 4 fires on either edge. Codes 5 to 15 never fire.
- R3: An input change sampled at a clock edge sets the pending bit at the third rising edge counted from that sample.
- R4: The enable word at window offset 0x10 has one bit per line. A pending line drives irq_o only while its enable bit is 1.
- R5: The pending word at window offset 0x14 is sticky and latches even while the line is disabled. A written 1 clears its bit, and a written 0 leaves it unchanged.
- R6: A new event and a clear of the same bit in the same cycle leave the bit set. In level modes this makes a clear ineffective while the level holds.
- R7: The word at window offset 0x18 reads back as written and has no effect on detection.
- R8: irq_o is the OR of pending-and-enabled bits over every line of every bank.
- R9: A line whose eint_sel_i bit is 0 never sets its pending bit.
- R10: All registers reset to zero. Reads of unmapped or misaligned addresses return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W (12) | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe |
| line_i | input | NUM_BANKS*LINES (64) | Asynchronous GPIO lines, bank b at [b*LINES +: LINES] |
| eint_sel_i | input | NUM_BANKS*LINES (64) | Per-line qualifier: pin is in its interrupt function |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four rules on every cycle:
- a line with a reserved code or a cleared qualifier never rises to pending;
- an active high level always leaves its bit set;
- a pending bit drops only when a written 1 clears it;
- irq_o falls only after a register write.

The bench's scenarios are needed for the rest: the three-edge detection latency, the field positions inside the configuration words, how each trigger code reacts to the opposite edge, and latching while a line is disabled. They also cover debounce-word independence and the decoding of unmapped and misaligned addresses.

// File: rtl/gpio_eint_pkg.sv
`timescale 1ns/1ps
package gpio_eint_pkg;
  localparam logic [3:0] TRIG_RISE = 4'd0;
  localparam logic [3:0] TRIG_FALL = 4'd1;
  localparam logic [3:0] TRIG_HIGH = 4'd2;
  localparam logic [3:0] TRIG_LOW  = 4'd3;
  localparam logic [3:0] TRIG_BOTH = 4'd4;

  localparam int unsigned WIN_BASE   = 'h200;
  localparam int unsigned WIN_STRIDE = 'h20;
  localparam int unsigned OFF_EN     = 'h10;
  localparam int unsigned OFF_ST     = 'h14;
  localparam int unsigned OFF_DEB    = 'h18;
endpackage

// File: rtl/gpio_eint_sync.sv
`timescale 1ns/1ps
module gpio_eint_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_eint_detect.sv
`timescale 1ns/1ps
module gpio_eint_detect
  import gpio_eint_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic       sel_i,
  output logic       hit_o
);
  logic raw;

  always_comb begin
    case (code_i)
      TRIG_RISE: raw = cur_i & ~prev_i;
      TRIG_FALL: raw = ~cur_i & prev_i;
      TRIG_HIGH: raw = cur_i;
      TRIG_LOW:  raw = ~cur_i;
      TRIG_BOTH: raw = cur_i ^ prev_i;
      default:   raw = 1'b0;
    endcase
  end

  assign hit_o = raw & sel_i;
endmodule

// File: rtl/gpio_eint_bank.sv
`timescale 1ns/1ps
module gpio_eint_bank
  import gpio_eint_pkg::*;
#(
  parameter int unsigned LINES = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned OFF_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [LINES-1:0] line_i,
  input  logic [LINES-1:0] sel_i,
  output logic             pend_o
);
  localparam int unsigned LPW       = DW / 4;
  localparam int unsigned CFG_WORDS = (LINES + LPW - 1) / LPW;

  logic [DW-1:0]    cfg_q [CFG_WORDS];
  logic [LINES-1:0] en_q, st_q;
  logic [DW-1:0]    deb_q;
  logic [LINES-1:0] cur_w, prev_q, hit_w, clr_w;

  gpio_eint_sync #(.W(LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .q_o    (cur_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_w;
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [3:0] code;
    assign code = cfg_q[n/LPW][4*(n%LPW) +: 4];

    gpio_eint_detect u_det (
      .code_i (code),
      .cur_i  (cur_w[n]),
      .prev_i (prev_q[n]),
      .sel_i  (sel_i[n]),
      .hit_o  (hit_w[n])
    );

    // R2
    rsv_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q[n]) |-> $past(code <= TRIG_BOTH));
    // R9
    unsel_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q[n]) |-> $past(sel_i[n]));
    // R6
    level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(code == TRIG_HIGH && cur_w[n] && sel_i[n]) |-> st_q[n]);
  end

  assign clr_w = (wr_i && off_i == OFF_W'(OFF_ST)) ? wdata_i[LINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < CFG_WORDS; w++) cfg_q[w] <= '0;
      en_q  <= '0;
      st_q  <= '0;
      deb_q <= '0;
    end else begin
      for (int w = 0; w < CFG_WORDS; w++)
        if (wr_i && off_i == OFF_W'(w*4)) cfg_q[w] <= wdata_i;
      if (wr_i && off_i == OFF_W'(OFF_EN))  en_q  <= wdata_i[LINES-1:0];
      if (wr_i && off_i == OFF_W'(OFF_DEB)) deb_q <= wdata_i;
      // new event wins over a same-cycle clear
      st_q <= (st_q & ~clr_w) | hit_w;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < CFG_WORDS; w++)
      if (off_i == OFF_W'(w*4)) rdata_o = cfg_q[w];
    if (off_i == OFF_W'(OFF_EN))  rdata_o = DW'(en_q);
    if (off_i == OFF_W'(OFF_ST))  rdata_o = DW'(st_q);
    if (off_i == OFF_W'(OFF_DEB)) rdata_o = deb_q;
  end

  assign pend_o = |(st_q & en_q);

  // R5
  w1c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) & ~$past(clr_w) & ~st_q) == '0);
endmodule

// File: rtl/gpio_eint_ctrl.sv
`timescale 1ns/1ps
module gpio_eint_ctrl
  import gpio_eint_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned LINES     = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_req_i,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [31:0]                reg_wdata_i,
  output logic [31:0]                reg_rdata_o,
  input  logic [NUM_BANKS*LINES-1:0] line_i,
  input  logic [NUM_BANKS*LINES-1:0] eint_sel_i,
  output logic                       irq_o
);
  localparam int unsigned DW    = 32;
  localparam int unsigned OFF_W = $clog2(WIN_STRIDE);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + WIN_STRIDE*NUM_BANKS);

  logic [ADDR_W-1:0]    rel_w;
  logic                 in_win_w;
  logic [NUM_BANKS-1:0] hit_w, pend_w;
  logic [DW-1:0]        brd_w [NUM_BANKS];

  assign in_win_w = ({1'b0, reg_addr_i} >= WIN_LO) && ({1'b0, reg_addr_i} < WIN_HI);
  assign rel_w    = reg_addr_i - WIN_LO[ADDR_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit_w[b] = reg_req_i && in_win_w &&
                      rel_w[ADDR_W-1:OFF_W] == (ADDR_W-OFF_W)'(b);

    gpio_eint_bank #(.LINES(LINES), .DW(DW), .OFF_W(OFF_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (hit_w[b] && reg_we_i),
      .off_i   (rel_w[OFF_W-1:0]),
      .wdata_i (reg_wdata_i),
      .rdata_o (brd_w[b]),
      .line_i  (line_i[b*LINES +: LINES]),
      .sel_i   (eint_sel_i[b*LINES +: LINES]),
      .pend_o  (pend_w[b])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (hit_w[b] && !reg_we_i) reg_rdata_o |= brd_w[b];
  end

  assign irq_o = |pend_w;

  // R4
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(reg_req_i && reg_we_i));
endmodule

// File: tb/gpio_eint_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_eint_ctrl_tb_top;
  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] lines = '0;
  logic [63:0] sel = '1;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_eint_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .line_i(lines), .eint_sel_i(sel), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_cfg [NB][4];
  logic [31:0] m_en [NB], m_st [NB], m_deb [NB], m_ev [NB], m_clr [NB];
  logic [63:0] m_s1, m_s, m_p;
  logic [11:0] m_rel;

  function automatic logic trig(input logic [3:0] c, input logic cur, input logic prv);
    case (c)
      4'd0: return cur && !prv;
      4'd1: return !cur && prv;
      4'd2: return cur;
      4'd3: return !cur;
      4'd4: return cur != prv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [11:0] r;
    if (a < 12'h200 || a >= 12'h240 || a[1:0] != 2'b00) return '0;
    r = a - 12'h200;
    if (r[4:0] < 5'd16) return m_cfg[r[5]][r[3:2]];
    case (r[4:0])
      5'd16: return m_en[r[5]];
      5'd20: return m_st[r[5]];
      5'd24: return m_deb[r[5]];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        for (int w = 0; w < 4; w++) m_cfg[b][w] = '0;
        m_en[b] = '0; m_st[b] = '0; m_deb[b] = '0;
      end
      m_s1 = '0; m_s = '0; m_p = '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        m_clr[b] = '0;
        for (int n = 0; n < 32; n++)
          m_ev[b][n] = sel[b*32+n] && trig(m_cfg[b][n/8][4*(n%8) +: 4], m_s[b*32+n], m_p[b*32+n]);
      end
      if (req && we && addr >= 12'h200 && addr < 12'h240 && addr[1:0] == 2'b00) begin
        m_rel = addr - 12'h200;
        if (m_rel[4:0] < 5'd16) m_cfg[m_rel[5]][m_rel[3:2]] = wdata;
        else if (m_rel[4:0] == 5'd16) m_en[m_rel[5]] = wdata;
        else if (m_rel[4:0] == 5'd20) m_clr[m_rel[5]] = wdata;
        else if (m_rel[4:0] == 5'd24) m_deb[m_rel[5]] = wdata;
      end
      for (int b = 0; b < NB; b++) m_st[b] = (m_st[b] & ~m_clr[b]) | m_ev[b];
      m_p = m_s; m_s = m_s1; m_s1 = lines;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({31'd0, irq}, {31'd0, |((m_st[0] & m_en[0]) | (m_st[1] & m_en[1]))}, "R8", "irq vs model");
      if (req && !we) chk(rdata, m_read(addr), "R1", "rdata vs model");
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    step();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    chk(rdata, exp, tag, "register read");
    step();
    req = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    chk({31'd0, irq}, {31'd0, exp}, tag, "irq");
  endtask

  initial begin
    #9 rst_n = 1'b1;
    step();
    // R10 reset state
    irq_chk(1'b0, "R10");
    rd_chk(12'h200, 32'h0, "R10");
    rd_chk(12'h210, 32'h0, "R10");
    rd_chk(12'h214, 32'h0, "R10");
    rd_chk(12'h218, 32'h0, "R10");
    rd_chk(12'h22C, 32'h0, "R10");
    rd_chk(12'h234, 32'h0, "R10");
    // R10 unmapped and misaligned
    wr(12'h21C, 32'hFFFF_FFFF);
    wr(12'h1FC, 32'hFFFF_FFFF);
    wr(12'h240, 32'hFFFF_FFFF);
    wr(12'h202, 32'hFFFF_FFFF);
    rd_chk(12'h21C, 32'h0, "R10");
    rd_chk(12'h240, 32'h0, "R10");
    rd_chk(12'h202, 32'h0, "R10");
    rd_chk(12'h200, 32'h0, "R10");
    // R1 line 10 -> word 1, bits 11:8, high level
    wr(12'h204, 32'h0000_0200);
    rd_chk(12'h204, 32'h0000_0200, "R1");
    wr(12'h210, 32'h1 << 10);
    lines[10] = 1'b1;
    step(2);
    irq_chk(1'b0, "R3");
    step();
    irq_chk(1'b1, "R3");
    wr(12'h214, 32'h1 << 10);
    rd_chk(12'h214, 32'h1 << 10, "R6");
    lines[10] = 1'b0;
    step(3);
    wr(12'h214, 32'h1 << 10);
    rd_chk(12'h214, 32'h0, "R5");
    irq_chk(1'b0, "R5");
    // bank 1: line 0 falling, line 1 both edges
    wr(12'h220, 32'h0000_0041);
    lines[32] = 1'b1; step(4);
    lines[32] = 1'b0; step(4);
    irq_chk(1'b0, "R4");
    rd_chk(12'h234, 32'h1, "R5");
    wr(12'h230, 32'h1);
    irq_chk(1'b1, "R4");
    wr(12'h234, 32'h0);
    rd_chk(12'h234, 32'h1, "R5");
    wr(12'h234, 32'h1);
    irq_chk(1'b0, "R5");
    lines[33] = 1'b1; step(4);
    rd_chk(12'h234, 32'h2, "R2");
    wr(12'h234, 32'h2);
    lines[33] = 1'b0; step(4);
    rd_chk(12'h234, 32'h2, "R2");
    wr(12'h234, 32'h2);
    // R2 reserved code 7 on line 2
    wr(12'h220, 32'h0000_0741);
    lines[34] = 1'b1; step(4);
    lines[34] = 1'b0; step(4);
    rd_chk(12'h234, 32'h0, "R2");
    // R2 rising-only on line 3
    lines[35] = 1'b1; step(4);
    rd_chk(12'h234, 32'h8, "R2");
    wr(12'h234, 32'h8);
    lines[35] = 1'b0; step(4);
    rd_chk(12'h234, 32'h0, "R2");
    // R9 line 5 unselected high level; line 4 low level
    sel[37] = 1'b0;
    wr(12'h220, 32'h0023_0741);
    lines[37] = 1'b1; step(4);
    rd_chk(12'h234, 32'h10, "R9");
    wr(12'h234, 32'h10);
    rd_chk(12'h234, 32'h10, "R6");
    lines[36] = 1'b1; step(3);
    wr(12'h234, 32'h10);
    rd_chk(12'h234, 32'h0, "R2");
    // R7 debounce word
    wr(12'h218, 32'h35);
    rd_chk(12'h218, 32'h35, "R7");
    wr(12'h238, 32'hA5);
    rd_chk(12'h238, 32'hA5, "R7");
    lines[35] = 1'b1; step(4);
    rd_chk(12'h234, 32'h8, "R7");
    // R8 merge over banks
    wr(12'h230, 32'h0);
    lines[10] = 1'b1; step(4);
    irq_chk(1'b1, "R8");
    wr(12'h210, 32'h0);
    irq_chk(1'b0, "R8");
    wr(12'h230, 32'h8);
    irq_chk(1'b1, "R8");
    step(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule